// File: doc/BRIEF.md
# Dual-Polynomial Serial CRC-16 Engine

This block computes a 16-bit cyclic redundancy check one bit per clock for a synchronous serial link. The transmitter uses it to build the frame check field, and the receiver uses it to test incoming frames. A configuration input chooses between two generator polynomials. A mode input chooses between bit-oriented framing and the other character-synchronous framings. The mode decides how the register is seeded, how the check field is presented and which final register value counts as a good frame.

Data enters least-significant bit first. The register follows the bit-reversed convention, so it shifts right and the reflected tap constants are used. The polynomial and mode are sampled while the enable is low and frozen while it is high. A change made in the middle of a frame therefore cannot corrupt the running value. When the link runs asynchronously the engine is idle.

Top module: `crc16_dual`

## Requirements
- R1: With `poly_sel`=1 the generator is x^16+x^15+x^2+1 (reflected taps 0xA001). In the non-bit-oriented mode the bytes 0x31..0x39, each sent LSB first, leave `crc_value`=0xBB3D.
- R2: With `poly_sel`=0 the generator is x^16+x^12+x^5+1 (reflected taps 0x8408). In the non-bit-oriented mode the same nine bytes leave `crc_value`=0x2189.
- R3: An `init` pulse while `sdlc_mode`=1 seeds the register with 0xFFFF. Because the output is complemented, `crc_value` then reads 0x0000.
- R4: An `init` pulse while `sdlc_mode`=0 clears the register to 0x0000, whichever polynomial is selected.
- R5: With `sdlc_mode`=1, `crc_value` is the ones' complement of the register. The nine-byte message gives 0x906E for `poly_sel`=0 and 0xB4C8 for `poly_sel`=1.
- R6: With `sdlc_mode`=1, `check_ok` is 1 exactly when the register holds the residue. The residue is 0xF0B8 (0x1D0F bit-reversed) for `poly_sel`=0 and 0xB001 for `poly_sel`=1. This is what a frame followed by its complemented check field, LSB first, produces.
- R7: With `sdlc_mode`=0, `check_ok` is 1 exactly when the register is zero. This holds after a frame followed by its plain check field, and after a clear.
- R8: While `sync_en`=0, `init` and data strobes leave the register unchanged and `check_ok` is 0.
- R9: While `crc_en` stays high, changes on `poly_sel` and `sdlc_mode` have no effect. The values present in the last cycle with `crc_en` low stay in force.
- R10: A bit is absorbed only in a cycle with `sync_en`, `crc_en` and `din_vld` all high.
- R11: When `init` and a data strobe fall in the same cycle, the preset wins and the bit is dropped.
- R12: After `rst` the register is zero and the configuration is `poly_sel`=0, non-bit-oriented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_en | input | 1 | Link is in a synchronous mode; engine idle when low |
| sdlc_mode | input | 1 | 1 = bit-oriented framing, 0 = other synchronous framing |
| poly_sel | input | 1 | 1 = x^16+x^15+x^2+1, 0 = x^16+x^12+x^5+1 |
| crc_en | input | 1 | Enables accumulation; freezes configuration while high |
| init | input | 1 | Preset strobe |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | Data bit strobe |
| crc_value | output | 16 | Running CRC in transmit form |
| check_ok | output | 1 | Register matches the good-frame value for the mode |

## Verification
The assertions take the three control inputs `sync_en`, `crc_en` and `init` to be known levels at every edge after reset. They do not depend on when `poly_sel` or `sdlc_mode` move. The stimulus changes every input only at the falling edge, holds `init` for a single cycle, and changes the configuration mid-frame only while `crc_en` is high. The engine is expected to ignore that change, and the stimulus confirms it does.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int CRC_W = 16;

    typedef enum logic {
        POLY_CCITT = 1'b0,
        POLY_ANSI  = 1'b1
    } poly_e;

    typedef struct packed {
        logic  sdlc;
        poly_e poly;
    } crc_cfg_t;

    function automatic logic [CRC_W-1:0] poly_taps(input poly_e p);
        return (p == POLY_ANSI) ? 16'hA001 : 16'h8408;
    endfunction

    function automatic logic [CRC_W-1:0] good_residue(input poly_e p);
        return (p == POLY_ANSI) ? 16'hB001 : 16'hF0B8;
    endfunction

    function automatic logic [CRC_W-1:0] seed_value(input logic sdlc);
        return sdlc ? {CRC_W{1'b1}} : {CRC_W{1'b0}};
    endfunction
endpackage

// File: rtl/crc16_cfg_hold.sv
module crc16_cfg_hold
    import crc16_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     freeze,
    input  crc_cfg_t cfg_live,
    output crc_cfg_t cfg_eff
);
    crc_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{sdlc: 1'b0, poly: POLY_CCITT};
        else if (!freeze)
            cfg_q <= cfg_live;
    end

    assign cfg_eff = freeze ? cfg_q : cfg_live;
endmodule

// File: rtl/crc16_lfsr.sv
module crc16_lfsr
    import crc16_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         load,
    input  logic         step,
    input  logic         din,
    input  logic [W-1:0] taps,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    logic         fb;
    logic [W-1:0] next_shift;

    always_comb begin
        fb         = state[0] ^ din;
        next_shift = (state >> 1) ^ (fb ? taps : '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else if (active) begin
            if (load)
                state <= seed;
            else if (step)
                state <= next_shift;
        end
    end
endmodule

// File: rtl/crc16_result.sv
module crc16_result
    import crc16_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic         active,
    input  crc_cfg_t     cfg,
    input  logic [W-1:0] state,
    output logic [W-1:0] tx_word,
    output logic         match
);
    logic [W-1:0] target;

    always_comb begin
        target  = cfg.sdlc ? good_residue(cfg.poly) : '0;
        tx_word = cfg.sdlc ? ~state : state;
        match   = active && (state == target);
    end
endmodule

// File: rtl/crc16_dual.sv
module crc16_dual
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_en,
    input  logic              sdlc_mode,
    input  logic              poly_sel,
    input  logic              crc_en,
    input  logic              init,
    input  logic              din,
    input  logic              din_vld,
    output logic [CRC_W-1:0]  crc_value,
    output logic              check_ok
);
    crc_cfg_t         cfg_live;
    crc_cfg_t         cfg_eff;
    logic [CRC_W-1:0] crc_q;

    assign cfg_live.sdlc = sdlc_mode;
    assign cfg_live.poly = poly_e'(poly_sel);

    crc16_cfg_hold u_cfg (
        .clk      (clk),
        .rst      (rst),
        .freeze   (crc_en),
        .cfg_live (cfg_live),
        .cfg_eff  (cfg_eff)
    );

    crc16_lfsr #(.W(CRC_W)) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .active (sync_en),
        .load   (init),
        .step   (crc_en && din_vld),
        .din    (din),
        .taps   (poly_taps(cfg_eff.poly)),
        .seed   (seed_value(cfg_eff.sdlc)),
        .state  (crc_q)
    );

    crc16_result #(.W(CRC_W)) u_res (
        .active  (sync_en),
        .cfg     (cfg_eff),
        .state   (crc_q),
        .tx_word (crc_value),
        .match   (check_ok)
    );
endmodule

// File: rtl/crc16_dual_chk.sv
module crc16_dual_chk
    import crc16_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sync_en,
    input logic             crc_en,
    input logic             din_vld,
    input logic             init,
    input logic             check_ok,
    input logic [CRC_W-1:0] crc_q,
    input crc_cfg_t         cfg_eff
);
    // R8: register frozen while the link is asynchronous
    p_async_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sync_en |=> $stable(crc_q));

    // R8: no pass indication while asynchronous
    p_async_nopass_r8: assert property (@(posedge clk) disable iff (rst)
        !sync_en |-> !check_ok);

    // R3: bit-oriented preset is all ones
    p_seed_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_en && init && cfg_eff.sdlc) |=> (crc_q == 16'hFFFF));

    // R4: other synchronous preset is all zeros
    p_seed_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (sync_en && init && !cfg_eff.sdlc) |=> (crc_q == 16'h0000));

    // R10: nothing absorbed without a full strobe
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!init && !(crc_en && din_vld)) |=> $stable(crc_q));

    // R9: configuration frozen while accumulation is enabled
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        crc_en |=> (!crc_en || $stable(cfg_eff)));
endmodule

bind crc16_dual crc16_dual_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_en  (sync_en),
    .crc_en   (crc_en),
    .din_vld  (din_vld),
    .init     (init),
    .check_ok (check_ok),
    .crc_q    (crc_q),
    .cfg_eff  (cfg_eff)
);

// File: tb/sim_crc16_dual.sv
`timescale 1ns/1ps
module sim_crc16_dual;
    logic        clk = 1'b0;
    logic        rst, sync_en, sdlc_mode, poly_sel, crc_en, init, din, din_vld;
    logic [15:0] crc_value;
    logic        check_ok;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] mdl;   // MSB-first (unreflected) reference remainder
    logic        mdl_sel;

    always #5 clk = ~clk;

    crc16_dual u0 (
        .clk(clk), .rst(rst), .sync_en(sync_en), .sdlc_mode(sdlc_mode),
        .poly_sel(poly_sel), .crc_en(crc_en), .init(init), .din(din),
        .din_vld(din_vld), .crc_value(crc_value), .check_ok(check_ok)
    );

    // {sdlc, sel, expected crc_value} for bytes 0x31..0x39
    localparam logic [17:0] VEC [4] = '{
        {1'b0, 1'b1, 16'hBB3D},   // R1
        {1'b0, 1'b0, 16'h2189},   // R2
        {1'b1, 1'b0, 16'h906E},   // R5
        {1'b1, 1'b1, 16'hB4C8}    // R5
    };

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        din = b; din_vld = 1'b1;
        if (sync_en && crc_en)
            mdl = {mdl[14:0], 1'b0} ^ ((mdl[15] ^ b) ? (mdl_sel ? 16'h8005 : 16'h1021) : 16'h0);
        @(negedge clk);
        din_vld = 1'b0;
    endtask

    task automatic start(input logic sd, input logic sel);
        sync_en = 1'b1; crc_en = 1'b0; sdlc_mode = sd; poly_sel = sel; init = 1'b1;
        @(negedge clk);
        init = 1'b0; crc_en = 1'b1;
        mdl = sd ? 16'hFFFF : 16'h0000; mdl_sel = sel;
    endtask

    task automatic send_msg();
        for (int k = 0; k < 9; k++) begin
            logic [7:0] by;
            by = 8'h31 + 8'(k);
            for (int j = 0; j < 8; j++) send_bit(by[j]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; sync_en = 1'b1; sdlc_mode = 1'b0; poly_sel = 1'b0;
        crc_en = 1'b1; init = 1'b0; din = 1'b0; din_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state, frozen config non-bit-oriented -> value 0, pass
        chk("R12 value", crc_value, 16'h0000);
        chk("R12 pass", {15'b0, check_ok}, 16'h1);

        // Vector walk: R1 R2 R5, then append check field for R6/R7
        for (int v = 0; v < 4; v++) begin
            logic [15:0] fcs;
            logic        sd;
            sd = VEC[v][17];
            start(sd, VEC[v][16]);
            send_msg();
            chk(sd ? "R5 vector" : (VEC[v][16] ? "R1 vector" : "R2 vector"), crc_value, VEC[v][15:0]);
            chk("model agree", crc_value, sd ? ~rev16(mdl) : rev16(mdl));
            fcs = crc_value;
            for (int j = 0; j < 16; j++) send_bit(fcs[j]);
            chk(sd ? "R6 pass" : "R7 pass", {15'b0, check_ok}, 16'h1);
            chk(sd ? "R6 residue" : "R7 residue", sd ? ~crc_value : crc_value,
                sd ? (VEC[v][16] ? 16'hB001 : 16'hF0B8) : 16'h0000);
        end

        // R6: corrupted frame does not pass
        start(1'b1, 1'b0);
        send_msg();
        begin
            logic [15:0] fcs;
            fcs = crc_value ^ 16'h0010;
            for (int j = 0; j < 16; j++) send_bit(fcs[j]);
        end
        chk("R6 bad frame", {15'b0, check_ok}, 16'h0);

        // R3: bit-oriented preset reads 0x0000 in complemented form
        start(1'b1, 1'b1);
        chk("R3 preset", crc_value, 16'h0000);
        chk("R3 no pass", {15'b0, check_ok}, 16'h0);

        // R4: clear from a nonzero state
        start(1'b0, 1'b1);
        send_bit(1'b1);
        chk("R4 nonzero", {15'b0, (crc_value != 16'h0)}, 16'h1);
        start(1'b0, 1'b1);
        chk("R4 clear", crc_value, 16'h0000);
        chk("R7 cleared pass", {15'b0, check_ok}, 16'h1);

        // R9: configuration changed mid-frame is ignored
        start(1'b0, 1'b0);
        for (int k = 0; k < 9; k++) begin
            logic [7:0] by;
            by = 8'h31 + 8'(k);
            if (k == 4) begin sdlc_mode = 1'b1; poly_sel = 1'b1; end
            for (int j = 0; j < 8; j++) send_bit(by[j]);
        end
        chk("R9 frozen", crc_value, 16'h2189);

        // R10: strobes without crc_en do nothing
        begin
            logic [15:0] hold;
            crc_en = 1'b0; sdlc_mode = 1'b0; poly_sel = 1'b0;
            @(negedge clk);
            hold = crc_value;
            for (int j = 0; j < 5; j++) begin
                din = 1'b1; din_vld = 1'b1; @(negedge clk);
            end
            din_vld = 1'b0;
            chk("R10 hold", crc_value, hold);

            // R8: asynchronous mode ignores strobes and init
            sync_en = 1'b0; crc_en = 1'b1;
            for (int j = 0; j < 4; j++) begin
                din = 1'b1; din_vld = 1'b1; @(negedge clk);
            end
            din_vld = 1'b0; init = 1'b1;
            @(negedge clk);
            init = 1'b0;
            chk("R8 hold", crc_value, hold);
            chk("R8 no pass", {15'b0, check_ok}, 16'h0);
        end

        // R11: preset wins over a coincident bit
        start(1'b0, 1'b0);
        send_bit(1'b1);
        init = 1'b1; din = 1'b1; din_vld = 1'b1;
        @(negedge clk);
        init = 1'b0; din_vld = 1'b0;
        chk("R11 preset wins", crc_value, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule